// File: doc/BRIEF.md
# SD/MMC Serial Clock Gate Controller

This block derives the card serial clock (SCK) from the system clock and decides, cycle by cycle, whether that clock toggles. It is placed beside the command and data engines of an SD/MMC host. The engines report their activity as levels: a command waiting to go out, a response still expected, a data transfer in progress, and the card holding DAT busy. They also report the state of the transfer FIFO and send one-cycle strobes when an error occurs. The block runs SCK while there is work. It freezes SCK while the FIFO cannot keep up, parks SCK on errors or when idle, and restarts it on a new request.

A programmable ratio sets the SCK half-period to `div_ratio + 1` system clocks. When idle, SCK either parks low or runs eight times slower, depending on a slow-idle enable. A continuous-clocking enable turns the activity and error gating off. Every start and stop happens only at the end of a low phase, so SCK never shows a shortened high or low phase.

Two state machines make up the block:
- The phase machine has the states `PH_PARK`, `PH_LOW` and `PH_HIGH`.
  - PARK→LOW when the gate decision asks for a clock.
  - LOW→HIGH at the end of a low phase while the clock is still wanted.
  - LOW→PARK at the end of a low phase once it is no longer wanted.
  - HIGH→LOW at the end of every high phase.
- The error machine has the states `ERR_CLEAR` and `ERR_HELD`.
  - CLEAR→HELD on any error strobe.
  - HELD→CLEAR on a software clear or a new operation request, provided no error strobe arrives in the same cycle.

Top module: `sdclk_gate_ctrl`

## Requirements
- R1: During and right after reset, `sck`, `sck_rise`, `clk_on` and `fifo_xrun` are all 0.
- R2: While running at full rate, each high phase and each low phase of `sck` lasts `div_ratio + 1` system clocks, so the period is `2*(div_ratio + 1)`.
- R3: While `run_en` is 0, `sck` does not toggle, in every mode.
- R4: With `cont_clk` = 0, any one of `cmd_pend`, `resp_pend`, `data_act` or `dat_busy` set to 1 (with no FIFO halt and no held error) keeps `sck` running at full rate, whatever the value of `slow_idle`.
- R5: When idle (all four activity levels 0), with `cont_clk` = 0 and `slow_idle` = 0, `sck` parks low.
- R6: When idle, with `cont_clk` = 0 and `slow_idle` = 1, each `sck` phase lasts `8*(div_ratio + 1)` system clocks.
- R7: With `cont_clk` = 1 and `run_en` = 1, `sck` runs at full rate regardless of activity, `slow_idle` and any held error.
- R8: With `data_act` = 1, `sck` is frozen in every mode when the FIFO cannot keep up. With `rx_dir` = 1 (receive) this means `rx_full` = 1. With `rx_dir` = 0 (transmit) it means `tx_empty` = 1. The FIFO flag of the other direction, and both flags while `data_act` = 0, have no effect.
- R9: With `cont_clk` = 0, a strobe on `r1_err`, `data_tmo` or `crc_err` stops `sck` even while activity is pending. `sck` stays stopped until a strobe on `err_clr` or `op_req`.
- R10: `sck` starts and stops only at the end of a low phase. Every high phase is a full half-period at the rate in force when the phase began, and no low phase is shorter than a half-period.
- R11: `sck_rise` is 1 for exactly the one system cycle in which `sck` has just gone from 0 to 1.
- R12: `clk_on` is 1 while the generator is in a low or high phase and 0 while it is parked. It is never 0 while `sck` is 1.
- R13: A strobe on `rx_ovf` or `tx_unf` sets `fifo_xrun` from the next cycle. `fifo_xrun` stays set until an `err_clr` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ratio | input | DIV_W | SCK half-period minus one, in system clocks |
| run_en | input | 1 | Master enable for SCK |
| cont_clk | input | 1 | Continuous clocking: ignore activity and errors |
| slow_idle | input | 1 | Run SCK at one eighth rate when idle |
| cmd_pend | input | 1 | Command waiting or being sent |
| resp_pend | input | 1 | Response still expected from the card |
| data_act | input | 1 | Data transfer in progress |
| dat_busy | input | 1 | Card holds DAT busy |
| rx_dir | input | 1 | Transfer direction: 1 receive, 0 transmit |
| rx_full | input | 1 | Receive FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| r1_err | input | 1 | Strobe: R1 status flagged an error |
| data_tmo | input | 1 | Strobe: data operation timed out |
| crc_err | input | 1 | Strobe: CRC mismatch detected |
| op_req | input | 1 | Strobe: new command or data operation requested |
| err_clr | input | 1 | Strobe: software clears error status |
| rx_ovf | input | 1 | Strobe: receive FIFO overflow |
| tx_unf | input | 1 | Strobe: transmit FIFO underflow |
| sck | output | 1 | Card serial clock |
| sck_rise | output | 1 | One-cycle pulse with each SCK rising edge |
| clk_on | output | 1 | Clock generator active (not parked) |
| fifo_xrun | output | 1 | Sticky FIFO overrun/underrun flag, usable as interrupt |

## Verification
The bench builds the block with `DIV_W` = 4 instead of the default 8. This keeps the widest ratio at 15, so the slow-idle limit reaches the all-ones top of the 7-bit phase counter within a few hundred cycles. At run time the bench uses ratios of 2, 0 and 15, which cover the ordinary case, the divide-by-two edge and the counter's full range in both rate modes. A ratio of 2 makes the full and slow periods (6 and 48 cycles) far enough apart that a wrong rate choice shows up in a single period measurement.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    // Slow idle rate is the programmed rate divided by 2**SLOW_SHIFT
    localparam int unsigned SLOW_SHIFT = 3;

    // SCK phase generator states
    typedef enum logic [1:0] {
        PH_PARK = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } ph_state_e;

    // Error hold states
    typedef enum logic {
        ERR_CLEAR = 1'b0,
        ERR_HELD  = 1'b1
    } err_state_e;

    // Gate decision bundle
    typedef struct packed {
        logic go;    // clock wanted
        logic slow;  // use the slow idle rate
    } gate_t;

endpackage

// File: rtl/sdclk_gate_dec.sv
module sdclk_gate_dec
    import sdclk_pkg::*;
(
    input  logic  run_en_i,
    input  logic  cont_i,
    input  logic  slow_en_i,
    input  logic  cmd_pend_i,
    input  logic  resp_pend_i,
    input  logic  data_act_i,
    input  logic  dat_busy_i,
    input  logic  rx_dir_i,
    input  logic  rx_full_i,
    input  logic  tx_empty_i,
    input  logic  err_hold_i,
    output gate_t gate_o
);

    logic fifo_stall;
    logic any_work;
    logic gated_want;

    // FIFO cannot keep up with the card in the current direction
    always_comb begin
        fifo_stall = 1'b0;
        if (data_act_i) begin
            fifo_stall = rx_dir_i ? rx_full_i : tx_empty_i;
        end
    end

    assign any_work = cmd_pend_i | resp_pend_i | data_act_i | dat_busy_i;

    // Demand when continuous clocking is off
    always_comb begin
        gated_want = 1'b0;
        if (!err_hold_i) begin
            gated_want = any_work | slow_en_i;
        end
    end

    always_comb begin
        gate_o.go   = run_en_i & ~fifo_stall & (cont_i | gated_want);
        gate_o.slow = ~cont_i & ~any_work & slow_en_i;
    end

endmodule

// File: rtl/sdclk_err_track.sv
module sdclk_err_track
    import sdclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic r1_err_i,
    input  logic tmo_i,
    input  logic crc_i,
    input  logic clr_i,
    input  logic op_req_i,
    input  logic ovf_i,
    input  logic unf_i,
    output logic hold_o,
    output logic xrun_o
);

    err_state_e err_q, err_d;
    logic       any_err;
    logic       xrun_q;

    assign any_err = r1_err_i | tmo_i | crc_i;

    // Next-state logic of the error hold machine
    always_comb begin
        err_d = err_q;
        unique case (err_q)
            ERR_CLEAR: begin
                if (any_err) err_d = ERR_HELD;
            end
            ERR_HELD: begin
                if (!any_err && (clr_i || op_req_i)) err_d = ERR_CLEAR;
            end
            default: err_d = ERR_CLEAR;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= ERR_CLEAR;
        end else begin
            err_q <= err_d;
        end
    end

    // Sticky FIFO overrun/underrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xrun_q <= 1'b0;
        end else if (ovf_i || unf_i) begin
            xrun_q <= 1'b1;
        end else if (clr_i) begin
            xrun_q <= 1'b0;
        end
    end

    assign hold_o = (err_q == ERR_HELD);
    assign xrun_o = xrun_q;

    AST_ERR_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |=> hold_o); // R9
    AST_ERR_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !clr_i && !op_req_i) |=> hold_o); // R9
    AST_XRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i || unf_i) |=> xrun_o); // R13
    AST_XRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (xrun_o && !clr_i) |=> xrun_o); // R13

endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
    import sdclk_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             slow_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam int unsigned CNT_W = DIV_W + SLOW_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] lim_d;
    logic             at_lim;

    // Slow limit is 8*(div+1)-1, i.e. div followed by ones
    generate
        if (SLOW_SHIFT > 0) begin : g_slow
            assign lim_d = slow_i ? {div_i, {SLOW_SHIFT{1'b1}}}
                                  : {{SLOW_SHIFT{1'b0}}, div_i};
        end else begin : g_noslow
            assign lim_d = div_i;
        end
    endgenerate

    assign at_lim = (cnt_q == lim_q);

    // Phase counter; the limit is latched at each phase start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (hold_i || at_lim) begin
            cnt_q <= '0;
            lim_q <= lim_d;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = ~hold_i & at_lim;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q); // R2
    AST_LIM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!hold_i && !at_lim)) |-> $stable(lim_q)); // R10

endmodule

// File: rtl/sdclk_phase_fsm.sv
module sdclk_phase_fsm
    import sdclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic tick_i,
    output logic hold_o,
    output logic sck_o,
    output logic rise_o,
    output logic on_o
);

    ph_state_e ph_q, ph_d;
    logic      sck_q;
    logic      rise_q;
    logic      on_q;

    // Next-state logic: start and stop only from the low phase
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_PARK: begin
                if (go_i) ph_d = PH_LOW;
            end
            PH_LOW: begin
                if (tick_i) ph_d = go_i ? PH_HIGH : PH_PARK;
            end
            PH_HIGH: begin
                if (tick_i) ph_d = PH_LOW;
            end
            default: ph_d = PH_PARK;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_PARK;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            rise_q <= 1'b0;
            on_q   <= 1'b0;
        end else begin
            sck_q  <= (ph_d == PH_HIGH);
            rise_q <= (ph_q == PH_LOW) && (ph_d == PH_HIGH);
            on_q   <= (ph_d != PH_PARK);
        end
    end

    assign hold_o = (ph_q == PH_PARK);
    assign sck_o  = sck_q;
    assign rise_o = rise_q;
    assign on_o   = on_q;

    AST_RISE_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_q) |-> $past(go_i)); // R10
    AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_q) |-> $past(tick_i)); // R10
    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> $rose(sck_q)); // R11
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |=> !rise_q); // R11
    AST_ON_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sck_q |-> on_q); // R12

endmodule

// File: rtl/sdclk_gate_ctrl.sv
module sdclk_gate_ctrl
    import sdclk_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic             run_en,
    input  logic             cont_clk,
    input  logic             slow_idle,
    input  logic             cmd_pend,
    input  logic             resp_pend,
    input  logic             data_act,
    input  logic             dat_busy,
    input  logic             rx_dir,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic             r1_err,
    input  logic             data_tmo,
    input  logic             crc_err,
    input  logic             op_req,
    input  logic             err_clr,
    input  logic             rx_ovf,
    input  logic             tx_unf,
    output logic             sck,
    output logic             sck_rise,
    output logic             clk_on,
    output logic             fifo_xrun
);

    gate_t gate;
    logic  err_hold;
    logic  div_hold;
    logic  div_tick;

    sdclk_err_track u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .r1_err_i (r1_err),
        .tmo_i    (data_tmo),
        .crc_i    (crc_err),
        .clr_i    (err_clr),
        .op_req_i (op_req),
        .ovf_i    (rx_ovf),
        .unf_i    (tx_unf),
        .hold_o   (err_hold),
        .xrun_o   (fifo_xrun)
    );

    sdclk_gate_dec u_dec (
        .run_en_i    (run_en),
        .cont_i      (cont_clk),
        .slow_en_i   (slow_idle),
        .cmd_pend_i  (cmd_pend),
        .resp_pend_i (resp_pend),
        .data_act_i  (data_act),
        .dat_busy_i  (dat_busy),
        .rx_dir_i    (rx_dir),
        .rx_full_i   (rx_full),
        .tx_empty_i  (tx_empty),
        .err_hold_i  (err_hold),
        .gate_o      (gate)
    );

    sdclk_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (div_hold),
        .slow_i (gate.slow),
        .div_i  (div_ratio),
        .tick_o (div_tick)
    );

    sdclk_phase_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (gate.go),
        .tick_i (div_tick),
        .hold_o (div_hold),
        .sck_o  (sck),
        .rise_o (sck_rise),
        .on_o   (clk_on)
    );

    AST_NO_RUN_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !sck_rise); // R3
    AST_IDLE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_clk && !slow_idle && !cmd_pend && !resp_pend && !data_act && !dat_busy)
        |=> !sck_rise); // R5
    AST_FIFO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_act && (rx_dir ? rx_full : tx_empty)) |=> !sck_rise); // R8
    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_hold && !cont_clk) |=> !sck_rise); // R9

endmodule

// File: tb/sim_sdclk_gate_ctrl.sv
`timescale 1ns/1ps
module sim_sdclk_gate_ctrl;

    localparam int unsigned DIV_W = 4;

    typedef struct packed {
        logic       run;
        logic       cont;
        logic       slow;
        logic       cmd;
        logic       resp;
        logic       dat;
        logic       busy;
        logic       rxdir;
        logic       rxfull;
        logic       txemp;
        logic [7:0] per;   // expected period at ratio 2, 0 = stopped
        logic [7:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{1,0,0,1,0,0,0,0,0,0, 8'd6,  8'd2},  // R2 command pending
        '{1,0,0,0,1,0,0,0,0,0, 8'd6,  8'd4},  // R4 response pending
        '{1,0,0,0,0,1,0,1,0,0, 8'd6,  8'd4},  // R4 data active, rx not full
        '{1,0,0,0,0,0,1,0,0,0, 8'd6,  8'd4},  // R4 DAT busy
        '{1,0,0,0,0,0,0,0,0,0, 8'd0,  8'd5},  // R5 idle parks
        '{1,0,1,0,0,0,0,0,0,0, 8'd48, 8'd6},  // R6 slow idle
        '{1,1,0,0,0,0,0,0,0,0, 8'd6,  8'd7},  // R7 continuous, idle
        '{1,1,1,0,0,0,0,0,0,0, 8'd6,  8'd7},  // R7 continuous beats slow
        '{0,1,0,1,0,0,0,0,0,0, 8'd0,  8'd3},  // R3 no run enable
        '{1,0,0,0,0,1,0,1,1,0, 8'd0,  8'd8},  // R8 rx full freezes
        '{1,0,0,0,0,1,0,0,0,1, 8'd0,  8'd8},  // R8 tx empty freezes
        '{1,0,0,0,0,1,0,0,1,0, 8'd6,  8'd8},  // R8 other-direction flag ignored
        '{1,0,0,1,0,0,0,0,1,1, 8'd6,  8'd8},  // R8 flags ignored without data
        '{1,1,0,0,0,1,0,1,1,0, 8'd0,  8'd8},  // R8 freeze under continuous
        '{1,0,1,0,0,0,1,0,0,0, 8'd6,  8'd4},  // R4 activity beats slow
        '{1,0,0,0,0,1,1,1,1,0, 8'd0,  8'd8}   // R8 freeze beats busy
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_r = 4'd2;
    logic run_en = 0, cont_clk = 0, slow_idle = 0;
    logic cmd_pend = 0, resp_pend = 0, data_act = 0, dat_busy = 0;
    logic rx_dir = 0, rx_full = 0, tx_empty = 0;
    logic r1_err = 0, data_tmo = 0, crc_err = 0, op_req = 0, err_clr = 0;
    logic rx_ovf = 0, tx_unf = 0;
    logic sck, sck_rise, clk_on, fifo_xrun;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdclk_gate_ctrl #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .div_ratio(div_r),
        .run_en(run_en), .cont_clk(cont_clk), .slow_idle(slow_idle),
        .cmd_pend(cmd_pend), .resp_pend(resp_pend), .data_act(data_act),
        .dat_busy(dat_busy), .rx_dir(rx_dir), .rx_full(rx_full),
        .tx_empty(tx_empty), .r1_err(r1_err), .data_tmo(data_tmo),
        .crc_err(crc_err), .op_req(op_req), .err_clr(err_clr),
        .rx_ovf(rx_ovf), .tx_unf(tx_unf),
        .sck(sck), .sck_rise(sck_rise), .clk_on(clk_on), .fifo_xrun(fifo_xrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Phase monitor for R10, R11, R12
    int  hi_len = 0, lo_len = 0;
    bit  prev_sck = 0;
    int  hi_bad = 0, lo_bad = 0, rise_bad = 0, on_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck) begin
                if (!prev_sck && lo_len < int'(div_r) + 1) lo_bad++;
                hi_len++;
                lo_len = 0;
            end else begin
                if (prev_sck && hi_len != int'(div_r) + 1 && hi_len != 8 * (int'(div_r) + 1))
                    hi_bad++;
                hi_len = 0;
                lo_len++;
            end
            if (sck_rise != (sck && !prev_sck)) rise_bad++;
            if (sck && !clk_on) on_bad++;
            prev_sck = sck;
        end
    end

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic measure(input int settle, input int lim, output int per);
        int c;
        per = 0;
        repeat (settle) @(negedge clk);
        c = 0;
        while (!sck_rise && c < lim) begin @(negedge clk); c++; end
        if (c >= lim) return;
        c = 0;
        do begin @(negedge clk); c++; end while (!sck_rise && c < lim);
        if (sck_rise) per = c;
    endtask

    task automatic expect_run(input string req, input int exp_per, input int lim);
        int per;
        measure(120, lim, per);
        chk(per == exp_per, req, per, exp_per);
        chk(clk_on == 1'b1, "R12 clk_on while running", int'(clk_on), 1);
    endtask

    task automatic expect_stop(input string req, input int settle);
        int rises = 0;
        bit hi = 0, on = 0;
        repeat (settle) @(negedge clk);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sck_rise) rises++;
            if (sck) hi = 1;
            if (clk_on) on = 1;
        end
        chk(rises == 0 && !hi, req, rises, 0);
        chk(!on, "R12 clk_on while parked", int'(on), 0);
    endtask

    task automatic park_and_set_div(input logic [DIV_W-1:0] d);
        @(negedge clk);
        run_en = 0; cont_clk = 0; slow_idle = 0;
        cmd_pend = 0; resp_pend = 0; data_act = 0; dat_busy = 0;
        rx_full = 0; tx_empty = 0;
        repeat (300) @(negedge clk);
        div_r = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (5) @(negedge clk);
        chk({sck, sck_rise, clk_on, fifo_xrun} == 4'b0, "R1 in reset",
            int'({sck, sck_rise, clk_on, fifo_xrun}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({sck, sck_rise, clk_on, fifo_xrun} == 4'b0, "R1 after reset",
            int'({sck, sck_rise, clk_on, fifo_xrun}), 0);

        // Table walk at ratio 2
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            run_en = VT[i].run; cont_clk = VT[i].cont; slow_idle = VT[i].slow;
            cmd_pend = VT[i].cmd; resp_pend = VT[i].resp; data_act = VT[i].dat;
            dat_busy = VT[i].busy; rx_dir = VT[i].rxdir;
            rx_full = VT[i].rxfull; tx_empty = VT[i].txemp;
            if (VT[i].per == 0)
                expect_stop($sformatf("R%0d vector %0d stopped", VT[i].req, i), 120);
            else
                expect_run($sformatf("R%0d vector %0d period", VT[i].req, i), int'(VT[i].per), 300);
        end

        // R2 high phase length at ratio 2
        park_and_set_div(4'd2);
        @(negedge clk); run_en = 1; cmd_pend = 1;
        begin
            int h = 0, w = 0;
            while (!sck_rise && w < 200) begin @(negedge clk); w++; end
            while (sck && h < 50) begin h++; @(negedge clk); end
            chk(h == 3, "R2 high phase length", h, 3);
        end

        // R9 error stops and restarts
        pulse(r1_err);
        expect_stop("R9 stop on r1_err", 120);
        pulse(err_clr);
        expect_run("R9 resume after err_clr", 6, 300);
        pulse(crc_err);
        expect_stop("R9 stop on crc_err", 120);
        pulse(op_req);
        expect_run("R9 resume after op_req", 6, 300);
        pulse(data_tmo);
        expect_stop("R9 stop on data_tmo", 120);
        @(negedge clk); cont_clk = 1;
        expect_run("R7 continuous ignores held error", 6, 300);
        @(negedge clk); cont_clk = 0;
        expect_stop("R9 hold persists", 120);
        pulse(err_clr);
        expect_run("R9 resume after second clear", 6, 300);

        // R13 sticky overrun/underrun flag
        pulse(rx_ovf);
        chk(fifo_xrun == 1'b1, "R13 set by rx_ovf", int'(fifo_xrun), 1);
        repeat (5) @(negedge clk);
        chk(fifo_xrun == 1'b1, "R13 held", int'(fifo_xrun), 1);
        pulse(err_clr);
        chk(fifo_xrun == 1'b0, "R13 cleared", int'(fifo_xrun), 0);
        pulse(tx_unf);
        chk(fifo_xrun == 1'b1, "R13 set by tx_unf", int'(fifo_xrun), 1);
        pulse(err_clr);
        chk(fifo_xrun == 1'b0, "R13 cleared again", int'(fifo_xrun), 0);

        // R2 ratio 0: divide by two
        park_and_set_div(4'd0);
        @(negedge clk); run_en = 1; cmd_pend = 1;
        expect_run("R2 ratio 0 period", 2, 300);

        // R2 / R6 largest ratio
        park_and_set_div(4'd15);
        @(negedge clk); run_en = 1; cmd_pend = 1;
        expect_run("R2 ratio 15 period", 32, 300);
        @(negedge clk); cmd_pend = 0; slow_idle = 1;
        expect_run("R6 ratio 15 slow period", 256, 600);

        park_and_set_div(4'd2);

        chk(hi_bad == 0, "R10 full high phases", hi_bad, 0);
        chk(lo_bad == 0, "R10 full low phases", lo_bad, 0);
        chk(rise_bad == 0, "R11 rise strobe alignment", rise_bad, 0);
        chk(on_bad == 0, "R12 clk_on covers high", on_bad, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule